// File: doc/BRIEF.md
# Load-Use Stall Unit

This unit guards a five-stage in-order pipeline against the one dependence that forwarding cannot cover: an instruction that needs a value a load has not yet brought back from memory. It sits beside the decode stage. Each cycle it compares the destination index of the instruction now in execute with the two source indices of the instruction now in decode. The comparison only counts when the execute instruction reads data memory.

When the compare hits, the unit holds the fetch address and the fetch/decode register for one cycle, so the same instruction is fetched and decoded again. It also switches the control bundle written into the decode/execute register to all zeros. That zero bundle is a bubble: it writes no register and no memory, and it does not read memory. On the next cycle the bubble is in execute, its read-memory flag is clear, and the held instruction moves on. Forwarding then resolves the dependence. The dependent instruction and everything behind it arrive in execute exactly one cycle later than they otherwise would.

The unit is purely combinational. The pipeline registers belong to the surrounding core.

Top module: `load_use_guard`

## Requirements
- R1: With `exMemRead` high and `exRt` nonzero and equal to `idRs`, a stall is signalled: `pcWrite`=0, `ifidWrite`=0, `ctrlZero`=1.
- R2: With `exMemRead` high and `exRt` nonzero and equal to `idRt`, a stall is signalled in the same way as in R1.
- R3: With `exMemRead` low, no stall is signalled, whatever the register indices are.
- R4: With `exMemRead` high and `exRt` equal to neither `idRs` nor `idRt`, no stall is signalled.
- R5: A load whose destination index is 0 never causes a stall, even when a source index is also 0.
- R6: When there is no stall, `pcWrite`=1, `ifidWrite`=1 and `ctrlZero`=0. This is also the state right after a pipeline reset, when the decode/execute register holds an all-zero bundle.
- R7: During a stall, `exCtrlNext`, `memCtrlNext` and `wbCtrlNext` are all zero. Otherwise they equal `idExCtrl`, `idMemCtrl` and `idWbCtrl` unchanged.
- R8: In a pipeline built around the unit, where bit 1 of the MEM control field is the read-memory flag fed back as `exMemRead`, a load followed by a dependent instruction gives exactly one stall cycle. In the cycle after the stall, no stall is signalled. The dependent instruction reaches execute one cycle late, and the instruction after it follows one cycle behind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| exMemRead | input | 1 | Read-memory flag of the instruction in the decode/execute register |
| exRt | input | REG_IDX_W | Destination index of that instruction (load target) |
| idRs | input | REG_IDX_W | First source index of the instruction in the fetch/decode register |
| idRt | input | REG_IDX_W | Second source index of the instruction in the fetch/decode register |
| idExCtrl | input | EX_CTRL_W | Decoded EX-stage control of the decode instruction |
| idMemCtrl | input | MEM_CTRL_W | Decoded MEM-stage control of the decode instruction |
| idWbCtrl | input | WB_CTRL_W | Decoded WB-stage control of the decode instruction |
| pcWrite | output | 1 | Enable for the fetch address register; low while stalling |
| ifidWrite | output | 1 | Enable for the fetch/decode register; low while stalling |
| ctrlZero | output | 1 | Select of the bubble multiplexer; high while stalling |
| exCtrlNext | output | EX_CTRL_W | EX control to be written into decode/execute |
| memCtrlNext | output | MEM_CTRL_W | MEM control to be written into decode/execute |
| wbCtrlNext | output | WB_CTRL_W | WB control to be written into decode/execute |

## Verification
The assertions assume that `exMemRead` belongs to the same instruction whose destination index is on `exRt`. They also assume that every input is a known value whenever they are evaluated. The bench meets both assumptions. In table mode it drives every input to a defined value before the inputs are sampled. In pipeline mode it takes `exMemRead` and `exRt` from a single modelled decode/execute register, so the flag and the index always travel together.

// File: rtl/hzd_types_pkg.sv
package hzd_types_pkg;

  // Strobes from the stall decision to the compare/mux path and the pipeline.
  typedef struct packed {
    logic holdPc;    // fetch address must not advance
    logic holdIfid;  // fetch/decode register must not load
    logic zeroCtrl;  // bubble: control bundle replaced by zeros
  } stallStrobes_t;

  localparam int unsigned SRC_PORTS = 2;  // two source indices checked in decode

endpackage

// File: rtl/hzd_compare_path.sv
module hzd_compare_path
  import hzd_types_pkg::*;
#(
  parameter int unsigned REG_IDX_W        = 5,
  parameter int unsigned EX_CTRL_W        = 4,
  parameter int unsigned MEM_CTRL_W       = 3,
  parameter int unsigned WB_CTRL_W        = 2,
  parameter bit          IGNORE_ZERO_DEST = 1'b1
) (
  input  logic [REG_IDX_W-1:0]  destIdx,
  input  logic [REG_IDX_W-1:0]  srcIdx [SRC_PORTS],
  input  logic [EX_CTRL_W-1:0]  realEx,
  input  logic [MEM_CTRL_W-1:0] realMem,
  input  logic [WB_CTRL_W-1:0]  realWb,
  input  stallStrobes_t         strobes,
  output logic [SRC_PORTS-1:0]  srcHit,
  output logic [EX_CTRL_W-1:0]  outEx,
  output logic [MEM_CTRL_W-1:0] outMem,
  output logic [WB_CTRL_W-1:0]  outWb
);

  localparam int unsigned BUNDLE_W = EX_CTRL_W + MEM_CTRL_W + WB_CTRL_W;

  logic destLive;
  logic [BUNDLE_W-1:0] realBundle;
  logic [BUNDLE_W-1:0] muxBundle;

  // The hard-wired zero register can never carry a pending load result.
  generate
    if (IGNORE_ZERO_DEST) begin : g_zeroGuard
      assign destLive = |destIdx;
    end else begin : g_noGuard
      assign destLive = 1'b1;
    end
  endgenerate

  // One equality comparator per source port.
  generate
    for (genvar p = 0; p < SRC_PORTS; p++) begin : g_cmp
      assign srcHit[p] = destLive && (srcIdx[p] == destIdx);
    end
  endgenerate

  // Bubble multiplexer: real control or all zeros.
  assign realBundle = {realEx, realMem, realWb};
  assign muxBundle  = strobes.zeroCtrl ? '0 : realBundle;
  assign {outEx, outMem, outWb} = muxBundle;

  always_comb begin
    a_r5_zero_dest_no_hit: assert (!(IGNORE_ZERO_DEST && destIdx == '0) || srcHit == '0)
      else $error("zero destination produced a hit");
    a_r7_bubble_zero: assert (!strobes.zeroCtrl || (outEx == '0 && outMem == '0 && outWb == '0))
      else $error("bubble carried nonzero control");
    a_r7_pass_through: assert (strobes.zeroCtrl ||
                               (outEx == realEx && outMem == realMem && outWb == realWb))
      else $error("control altered without a stall");
  end

endmodule

// File: rtl/hzd_stall_ctrl.sv
module hzd_stall_ctrl
  import hzd_types_pkg::*;
(
  input  logic                 exIsLoad,
  input  logic [SRC_PORTS-1:0] srcHit,
  output stallStrobes_t        strobes
);

  logic stallNow;

  // Only a memory read in execute can leave decode waiting on its result.
  assign stallNow = exIsLoad && (|srcHit);

  always_comb begin
    strobes.holdPc   = stallNow;
    strobes.holdIfid = stallNow;
    strobes.zeroCtrl = stallNow;
  end

  always_comb begin
    a_r3_no_load_no_stall: assert (exIsLoad || !strobes.zeroCtrl)
      else $error("stall without a load in execute");
    a_r4_no_hit_no_stall: assert ((|srcHit) || !strobes.holdPc)
      else $error("stall without a source match");
    a_r6_strobes_together: assert (strobes.holdPc == strobes.holdIfid &&
                                   strobes.holdIfid == strobes.zeroCtrl)
      else $error("hold and bubble strobes disagree");
  end

endmodule

// File: rtl/load_use_guard.sv
module load_use_guard
  import hzd_types_pkg::*;
#(
  parameter int unsigned REG_IDX_W        = 5,
  parameter int unsigned EX_CTRL_W        = 4,
  parameter int unsigned MEM_CTRL_W       = 3,
  parameter int unsigned WB_CTRL_W        = 2,
  parameter bit          IGNORE_ZERO_DEST = 1'b1
) (
  input  logic                  exMemRead,
  input  logic [REG_IDX_W-1:0]  exRt,
  input  logic [REG_IDX_W-1:0]  idRs,
  input  logic [REG_IDX_W-1:0]  idRt,
  input  logic [EX_CTRL_W-1:0]  idExCtrl,
  input  logic [MEM_CTRL_W-1:0] idMemCtrl,
  input  logic [WB_CTRL_W-1:0]  idWbCtrl,
  output logic                  pcWrite,
  output logic                  ifidWrite,
  output logic                  ctrlZero,
  output logic [EX_CTRL_W-1:0]  exCtrlNext,
  output logic [MEM_CTRL_W-1:0] memCtrlNext,
  output logic [WB_CTRL_W-1:0]  wbCtrlNext
);

  logic [REG_IDX_W-1:0] srcIdx [SRC_PORTS];
  logic [SRC_PORTS-1:0] srcHit;
  stallStrobes_t        strobes;

  assign srcIdx[0] = idRs;
  assign srcIdx[1] = idRt;

  hzd_compare_path #(
    .REG_IDX_W       (REG_IDX_W),
    .EX_CTRL_W       (EX_CTRL_W),
    .MEM_CTRL_W      (MEM_CTRL_W),
    .WB_CTRL_W       (WB_CTRL_W),
    .IGNORE_ZERO_DEST(IGNORE_ZERO_DEST)
  ) i_path (
    .destIdx(exRt),
    .srcIdx (srcIdx),
    .realEx (idExCtrl),
    .realMem(idMemCtrl),
    .realWb (idWbCtrl),
    .strobes(strobes),
    .srcHit (srcHit),
    .outEx  (exCtrlNext),
    .outMem (memCtrlNext),
    .outWb  (wbCtrlNext)
  );

  hzd_stall_ctrl i_ctrl (
    .exIsLoad(exMemRead),
    .srcHit  (srcHit),
    .strobes (strobes)
  );

  assign pcWrite   = !strobes.holdPc;
  assign ifidWrite = !strobes.holdIfid;
  assign ctrlZero  = strobes.zeroCtrl;

  always_comb begin
    a_r1_rs_match_stalls: assert (!(exMemRead && exRt != '0 && exRt == idRs) || !pcWrite)
      else $error("load hazard on first source missed");
    a_r2_rt_match_stalls: assert (!(exMemRead && exRt != '0 && exRt == idRt) || !ifidWrite)
      else $error("load hazard on second source missed");
  end

endmodule

// File: tb/test_load_use_guard.sv
module test_load_use_guard;

  localparam int unsigned RW = 5;

  logic clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic          exMemRead;
  logic [RW-1:0] exRt, idRs, idRt;
  logic [3:0]    idExCtrl;
  logic [2:0]    idMemCtrl;
  logic [1:0]    idWbCtrl;
  logic          pcWrite, ifidWrite, ctrlZero;
  logic [3:0]    exCtrlNext;
  logic [2:0]    memCtrlNext;
  logic [1:0]    wbCtrlNext;

  load_use_guard i_load_use_guard (
    .exMemRead(exMemRead), .exRt(exRt), .idRs(idRs), .idRt(idRt),
    .idExCtrl(idExCtrl), .idMemCtrl(idMemCtrl), .idWbCtrl(idWbCtrl),
    .pcWrite(pcWrite), .ifidWrite(ifidWrite), .ctrlZero(ctrlZero),
    .exCtrlNext(exCtrlNext), .memCtrlNext(memCtrlNext), .wbCtrlNext(wbCtrlNext)
  );

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  function automatic string reqLabel(input int id);
    case (id)
      1: return "R1"; 2: return "R2"; 3: return "R3"; 4: return "R4";
      5: return "R5"; 6: return "R6"; 7: return "R7"; default: return "R8";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic checkStall(input bit expStall, input string req);
    check(pcWrite == !expStall, req, pcWrite, !expStall);
    check(ifidWrite == !expStall, {req, "/R6 ifidWrite"}, ifidWrite, !expStall);
    check(ctrlZero == expStall, {req, "/R6 ctrlZero"}, ctrlZero, expStall);
  endtask

  // {reqId[3:0], isLoad, exRt[4:0], idRs[4:0], idRt[4:0], expStall}
  localparam int NV = 10;
  localparam logic [20:0] VEC [NV] = '{
    {4'd1, 1'b1, 5'd3,  5'd3,  5'd9,  1'b1},
    {4'd2, 1'b1, 5'd7,  5'd1,  5'd7,  1'b1},
    {4'd1, 1'b1, 5'd31, 5'd31, 5'd31, 1'b1},
    {4'd3, 1'b0, 5'd3,  5'd3,  5'd3,  1'b0},
    {4'd3, 1'b0, 5'd8,  5'd2,  5'd8,  1'b0},
    {4'd4, 1'b1, 5'd4,  5'd5,  5'd6,  1'b0},
    {4'd4, 1'b1, 5'd1,  5'd2,  5'd0,  1'b0},
    {4'd5, 1'b1, 5'd0,  5'd0,  5'd0,  1'b0},
    {4'd5, 1'b1, 5'd0,  5'd0,  5'd4,  1'b0},
    {4'd2, 1'b1, 5'd16, 5'd17, 5'd16, 1'b1}
  };

  // Pipeline model: instruction = {rs, rt, ex, mem, wb}; MEM bit 1 reads memory.
  typedef struct packed {
    logic [RW-1:0] rs;
    logic [RW-1:0] rt;
    logic [3:0]    ex;
    logic [2:0]    mem;
    logic [1:0]    wb;
  } instr_t;

  function automatic instr_t prog(input int idx);
    case (idx)
      0: return '{rs: 5'd1, rt: 5'd2, ex: 4'h1, mem: 3'b010, wb: 2'b11}; // load into 2
      1: return '{rs: 5'd2, rt: 5'd5, ex: 4'h2, mem: 3'b000, wb: 2'b10}; // uses 2
      2: return '{rs: 5'd6, rt: 5'd7, ex: 4'h3, mem: 3'b000, wb: 2'b10};
      default: return '{rs: 5'd8, rt: 5'd9, ex: 4'h4, mem: 3'b000, wb: 2'b10};
    endcase
  endfunction

  int     pc;
  instr_t ifid;
  int     ifidTag;
  logic [3:0] xEx; logic [2:0] xMem; logic [1:0] xWb;
  logic [RW-1:0] xRt;
  int     xTag;
  int     stallsSeen;

  task automatic driveFromModel();
    exMemRead = xMem[1];
    exRt      = xRt;
    idRs      = ifid.rs;
    idRt      = ifid.rt;
    idExCtrl  = ifid.ex;
    idMemCtrl = ifid.mem;
    idWbCtrl  = ifid.wb;
  endtask

  task automatic stepPipe();
    instr_t nxtIfid;
    int     nxtTag;
    @(posedge clk);
    #1;
    if (!pcWrite) stallsSeen++;
    nxtIfid = ifidWrite ? prog(pc) : ifid;
    nxtTag  = ifidWrite ? pc : ifidTag;
    xEx = exCtrlNext; xMem = memCtrlNext; xWb = wbCtrlNext;
    xRt = ifid.rt; xTag = ifidTag;
    if (pcWrite) pc = pc + 1;
    ifid = nxtIfid; ifidTag = nxtTag;
    driveFromModel();
    @(negedge clk);
  endtask

  initial begin
    // ---- table of vectors ----
    idExCtrl = 4'hA; idMemCtrl = 3'b101; idWbCtrl = 2'b11;
    exMemRead = 0; exRt = 0; idRs = 0; idRt = 0;
    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      string rq;
      bit    es;
      rq = reqLabel(int'(VEC[i][20:17]));
      exMemRead = VEC[i][16];
      exRt      = VEC[i][15:11];
      idRs      = VEC[i][10:6];
      idRt      = VEC[i][5:1];
      es        = VEC[i][0];
      @(negedge clk);
      checkStall(es, rq);
      // R7: bubble zeroes control, otherwise it passes unchanged
      check(exCtrlNext == (es ? 4'h0 : 4'hA), "R7 ex", exCtrlNext, es ? 0 : 10);
      check(memCtrlNext == (es ? 3'b000 : 3'b101), "R7 mem", memCtrlNext, es ? 0 : 5);
      check(wbCtrlNext == (es ? 2'b00 : 2'b11), "R7 wb", wbCtrlNext, es ? 0 : 3);
    end

    // ---- pipeline model: reset state ----
    pc = 0; ifid = '0; ifidTag = -1;
    xEx = '0; xMem = '0; xWb = '0; xRt = '0; xTag = -1; stallsSeen = 0;
    driveFromModel();
    @(negedge clk);
    checkStall(1'b0, "R6 reset");

    stepPipe();  // load in decode
    checkStall(1'b0, "R8 load in decode");
    stepPipe();  // load in execute, user in decode
    checkStall(1'b1, "R1 load-use");
    check(xTag == 0, "R8 load in execute", xTag, 0);
    stepPipe();  // stall edge: bubble into execute
    checkStall(1'b0, "R8 no second stall");
    check(pc == 2, "R6 pc held", pc, 2);
    check(ifidTag == 1, "R6 ifid held", ifidTag, 1);
    check({xEx, xMem, xWb} == 9'd0, "R7 bubble in execute", {xEx, xMem, xWb}, 0);
    stepPipe();
    check(xTag == 1 && xEx == 4'h2, "R8 dependent slipped one cycle", xTag, 1);
    stepPipe();
    check(xTag == 2 && xEx == 4'h3, "R8 next instruction follows", xTag, 2);
    check(stallsSeen == 1, "R8 single stall", stallsSeen, 1);

    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    #(200000 * 20);
    if (!finished) begin
      finished = 1'b1;
      nChecks++; nFails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule